// File: doc/BRIEF.md
# Serial Scan SRAM Test Controller

This block lets a tester exercise a bank of up to sixteen on-chip SRAM macros through a single serial pin pair. A 112-bit command word is shifted in one bit per clock. It carries a slot number and a full command set for each of two memory ports: address, write word, active-low enable, active-low write strobe and byte mask. Raising the apply strobe then drives those commands onto shared port buses. Each slot has its own chip-select line per port, and only the chosen slot's line carries the command's select bit.

While the apply strobe is held, every clock copies the chosen slot's read word into the data field of each port that is reading. Shifting the register back out returns the command with the results filled in, so the same word serves as request and reply. The memories register their reads, so the apply strobe is held for two clocks. On the first edge the memory fetches the word, and on the second edge the controller captures it. Repeating a write on the second edge leaves the memory unchanged.

Top module: `sram_scan_ctrl`

## Requirements
- R1: A synchronous reset loads the register with all zeros, except the two port enable bits (bit 59 for port 0, bit 5 for port 1), which become 1. After reset, every chip-select output is high.
- R2: The register is 112 bits wide. While scan_en is high it shifts toward the MSB by one bit each clock, scan_in enters at bit 0, and scan_out always shows bit 111. A word shifted in comes back out unchanged after 112 further shifts.
- R3: While apply_en is low, every chip-select output on both ports is high.
- R4: While apply_en is high and scan_en is low, the chip-select bit of the slot named by bits 111:108 equals that port's enable bit (0 = active), and all other slots are high.
- R5: The address, write word, write strobe and byte mask outputs of port 0 show bits 107:92, 91:60, 58 and 57:54. Port 1 uses bits 53:38, 37:6, 4 and 3:0. Write strobe 0 means write and 1 means read. Mask bit i covers byte i of the word.
- R6: On each clock with apply_en high and scan_en low, each port whose enable bit is 0 and whose write strobe is 1 loads the selected slot's read word for that port into its data field.
- R7: Data fields of ports that are idle (enable 1) or writing (strobe 0) keep their value during apply. The register holds when both scan_en and apply_en are low.
- R8: scan_en has priority over apply_en. With both high the register shifts, no capture takes place, and all chip selects stay high.
- R9: The read word is taken from the lane of the selected slot on the wide read-data buses. A lane that carries zero, such as port 1 of a single-port slot (slots 8 to 11), returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and memory clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Shift enable |
| scan_in | input | 1 | Serial data in, MSB first |
| apply_en | input | 1 | Drive commands and capture reads |
| scan_out | output | 1 | Serial data out, register MSB |
| m0_addr | output | 16 | Port 0 address bus |
| m0_wdata | output | 32 | Port 0 write word |
| m0_web | output | 1 | Port 0 write strobe, low = write |
| m0_wmask | output | 4 | Port 0 byte mask |
| m0_csb | output | 16 | Port 0 per-slot chip select, active low |
| m1_addr | output | 16 | Port 1 address bus |
| m1_wdata | output | 32 | Port 1 write word |
| m1_web | output | 1 | Port 1 write strobe, low = write |
| m1_wmask | output | 4 | Port 1 byte mask |
| m1_csb | output | 16 | Port 1 per-slot chip select, active low |
| m0_rdata_bus | input | 512 | Port 0 read words, slot s in bits 32s+31:32s |
| m1_rdata_bus | input | 512 | Port 1 read words, same lane order |

## Verification
The bus and chip-select outputs are combinational from the register. They are checked on the falling edge after the first apply edge, while apply_en is still high. With a memory that registers its reads, the correct word reaches the data field only on the second apply edge. For that reason the scoreboard compares read results when the word is shifted out, and never sooner. Because scan_out shows the MSB before any shift edge, each bit is sampled on the falling edge before the rising edge that moves it. The reply to one command is collected while the next command is shifted in.

// File: rtl/sram_scan_pkg.sv
package sram_scan_pkg;
    localparam int SEL_W  = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int MASK_W = DATA_W / 8;
    localparam int SLOTS  = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              csb;
        logic              web;
        logic [MASK_W-1:0] mask;
    } port_cmd_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        port_cmd_t        p0;
        port_cmd_t        p1;
    } scan_pkt_t;

    localparam int PKT_W = $bits(scan_pkt_t);

    function automatic scan_pkt_t idle_pkt();
        scan_pkt_t r;
        r        = '0;
        r.p0.csb = 1'b1;
        r.p1.csb = 1'b1;
        return r;
    endfunction

    function automatic logic is_read(port_cmd_t c);
        return (!c.csb) && c.web;
    endfunction

    function automatic port_cmd_t capture(port_cmd_t c, logic [DATA_W-1:0] rd);
        port_cmd_t r;
        r = c;
        if (is_read(c)) r.data = rd;
        return r;
    endfunction
endpackage

// File: rtl/sram_scan_cs_fanout.sv
module sram_scan_cs_fanout #(
    parameter int SLOTS = 16,
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             cs_n,
    input  logic             drive,
    output logic [SLOTS-1:0] csb_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign csb_o[g] = !(drive && (int'(sel) == g) && !cs_n);
    end
endmodule

// File: rtl/sram_scan_rd_mux.sv
module sram_scan_rd_mux #(
    parameter int SLOTS  = 16,
    parameter int SEL_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic [SLOTS*DATA_W-1:0] bus,
    input  logic [SEL_W-1:0]        sel,
    output logic [DATA_W-1:0]       word
);
    always_comb begin
        word = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (int'(sel) == s) word = bus[s*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/sram_scan_pkt_reg.sv
module sram_scan_pkt_reg
    import sram_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scan_en,
    input  logic              scan_in,
    input  logic              load_en,
    input  logic [DATA_W-1:0] rd0,
    input  logic [DATA_W-1:0] rd1,
    output scan_pkt_t         q,
    output logic              scan_out
);
    logic [PKT_W-1:0] qv;
    scan_pkt_t        nxt;

    assign qv       = q;
    assign scan_out = qv[PKT_W-1];

    always_comb begin
        nxt = q;
        if (scan_en) begin
            nxt = scan_pkt_t'({qv[PKT_W-2:0], scan_in});
        end else if (load_en) begin
            nxt.p0 = capture(q.p0, rd0);
            nxt.p1 = capture(q.p1, rd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= idle_pkt();
        else     q <= nxt;
    end

    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (qv[0] == $past(scan_in)) && (qv[PKT_W-1:1] == $past(qv[PKT_W-2:0])));
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !load_en) |=> $stable(qv));
    assert_capture_p0_R6: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && load_en && !q.p0.csb && q.p0.web) |=> (q.p0.data == $past(rd0)));
    assert_capture_p1_R6: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && load_en && !q.p1.csb && q.p1.web) |=> (q.p1.data == $past(rd1)));
    assert_keep_p0_R7: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && load_en && (q.p0.csb || !q.p0.web)) |=> $stable(q.p0.data));
    assert_keep_p1_R7: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && load_en && (q.p1.csb || !q.p1.web)) |=> $stable(q.p1.data));
endmodule

// File: rtl/sram_scan_ctrl.sv
module sram_scan_ctrl
    import sram_scan_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scan_en,
    input  logic                    scan_in,
    input  logic                    apply_en,
    output logic                    scan_out,
    output logic [ADDR_W-1:0]       m0_addr,
    output logic [DATA_W-1:0]       m0_wdata,
    output logic                    m0_web,
    output logic [MASK_W-1:0]       m0_wmask,
    output logic [SLOTS-1:0]        m0_csb,
    output logic [ADDR_W-1:0]       m1_addr,
    output logic [DATA_W-1:0]       m1_wdata,
    output logic                    m1_web,
    output logic [MASK_W-1:0]       m1_wmask,
    output logic [SLOTS-1:0]        m1_csb,
    input  logic [SLOTS*DATA_W-1:0] m0_rdata_bus,
    input  logic [SLOTS*DATA_W-1:0] m1_rdata_bus
);
    scan_pkt_t         pkt;
    logic [DATA_W-1:0] rd0_word;
    logic [DATA_W-1:0] rd1_word;
    logic              drive;

    assign drive = apply_en && !scan_en;

    sram_scan_rd_mux #(.SLOTS(SLOTS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_rd0 (
        .bus(m0_rdata_bus), .sel(pkt.sel), .word(rd0_word));
    sram_scan_rd_mux #(.SLOTS(SLOTS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_rd1 (
        .bus(m1_rdata_bus), .sel(pkt.sel), .word(rd1_word));

    sram_scan_pkt_reg u_reg (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .load_en(apply_en), .rd0(rd0_word), .rd1(rd1_word),
        .q(pkt), .scan_out(scan_out));

    sram_scan_cs_fanout #(.SLOTS(SLOTS), .SEL_W(SEL_W)) u_cs0 (
        .sel(pkt.sel), .cs_n(pkt.p0.csb), .drive(drive), .csb_o(m0_csb));
    sram_scan_cs_fanout #(.SLOTS(SLOTS), .SEL_W(SEL_W)) u_cs1 (
        .sel(pkt.sel), .cs_n(pkt.p1.csb), .drive(drive), .csb_o(m1_csb));

    assign m0_addr  = pkt.p0.addr;
    assign m0_wdata = pkt.p0.data;
    assign m0_web   = pkt.p0.web;
    assign m0_wmask = pkt.p0.mask;
    assign m1_addr  = pkt.p1.addr;
    assign m1_wdata = pkt.p1.data;
    assign m1_web   = pkt.p1.web;
    assign m1_wmask = pkt.p1.mask;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> ((&m0_csb) && (&m1_csb) && !scan_out));
    assert_idle_cs_R3: assert property (@(posedge clk) disable iff (rst)
        !apply_en |-> ((&m0_csb) && (&m1_csb)));
    assert_scan_first_R8: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> ((&m0_csb) && (&m1_csb)));
    assert_one_slot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~m0_csb) && $onehot0(~m1_csb));
endmodule

// File: tb/test_sram_scan_ctrl.sv
`timescale 1ns/1ps
module test_sram_scan_ctrl;
    import sram_scan_pkg::*;

    logic clk = 1'b0;
    logic rst, scan_en, scan_in, apply_en, scan_out;
    logic [15:0] m0_addr, m1_addr, m0_csb, m1_csb;
    logic [31:0] m0_wdata, m1_wdata;
    logic m0_web, m1_web;
    logic [3:0] m0_wmask, m1_wmask;
    logic [16*32-1:0] rd0_bus, rd1_bus;

    always #2.5 clk = ~clk;

    sram_scan_ctrl i_sram_scan_ctrl (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .apply_en(apply_en), .scan_out(scan_out),
        .m0_addr(m0_addr), .m0_wdata(m0_wdata), .m0_web(m0_web),
        .m0_wmask(m0_wmask), .m0_csb(m0_csb),
        .m1_addr(m1_addr), .m1_wdata(m1_wdata), .m1_web(m1_web),
        .m1_wmask(m1_wmask), .m1_csb(m1_csb),
        .m0_rdata_bus(rd0_bus), .m1_rdata_bus(rd1_bus));

    // Behavioural memory bank: slots 0-4 dual port, 8-11 single port, registered reads
    logic [31:0] mem [16][64];
    logic [31:0] dout0 [16];
    logic [31:0] dout1 [16];

    function automatic bit slot_on(int s);
        return (s <= 4) || (s >= 8 && s <= 11);
    endfunction

    always_comb begin
        for (int s = 0; s < 16; s++) begin
            rd0_bus[s*32 +: 32] = dout0[s];
            rd1_bus[s*32 +: 32] = (s <= 4) ? dout1[s] : 32'h0;
        end
    end

    always @(posedge clk) begin
        for (int s = 0; s < 16; s++) begin
            if (slot_on(s) && !m0_csb[s]) begin
                if (!m0_web) begin
                    for (int b = 0; b < 4; b++)
                        if (m0_wmask[b]) mem[s][m0_addr[5:0]][8*b +: 8] <= m0_wdata[8*b +: 8];
                end else dout0[s] <= mem[s][m0_addr[5:0]];
            end
            if (s <= 4 && !m1_csb[s]) begin
                if (!m1_web) begin
                    for (int b = 0; b < 4; b++)
                        if (m1_wmask[b]) mem[s][m1_addr[5:0]][8*b +: 8] <= m1_wdata[8*b +: 8];
                end else dout1[s] <= mem[s][m1_addr[5:0]];
            end
        end
    end

    // Bench-side expectation state
    logic [31:0] shadow [16][64];
    int n_chk = 0;
    int n_err = 0;
    scan_pkt_t exp_q[$];
    string     tag_q[$];

    task automatic chk(string tag, logic [111:0] act, logic [111:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (m[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    function automatic scan_pkt_t predict(scan_pkt_t p);
        scan_pkt_t e = p;
        int s = int'(p.sel);
        if (!p.p0.csb) begin
            if (!p.p0.web) begin
                if (slot_on(s)) shadow[s][p.p0.addr[5:0]] = merge(shadow[s][p.p0.addr[5:0]], p.p0.data, p.p0.mask);
            end else e.p0.data = slot_on(s) ? shadow[s][p.p0.addr[5:0]] : 32'h0;
        end
        if (!p.p1.csb) begin
            if (!p.p1.web) begin
                if (s <= 4) shadow[s][p.p1.addr[5:0]] = merge(shadow[s][p.p1.addr[5:0]], p.p1.data, p.p1.mask);
            end else e.p1.data = (s <= 4) ? shadow[s][p.p1.addr[5:0]] : 32'h0;
        end
        return e;
    endfunction

    // Shift a word in while the previous word comes out; monitor pops the scoreboard
    task automatic shift_word(scan_pkt_t din, logic with_apply);
        logic [111:0] dv = din;
        logic [111:0] got;
        scan_en  = 1'b1;
        apply_en = with_apply;
        for (int i = 0; i < 112; i++) begin
            scan_in = dv[111-i];
            got[111-i] = scan_out;
            if (i == 7)
                chk(with_apply ? "R8 csb during shift with apply" : "R3 csb during shift",
                    {80'h0, m0_csb, m1_csb}, {80'h0, 16'hFFFF, 16'hFFFF});
            @(posedge clk);
            @(negedge clk);
        end
        scan_en  = 1'b0;
        apply_en = 1'b0;
        if (exp_q.size() > 0) begin
            scan_pkt_t e = exp_q.pop_front();
            string t = tag_q.pop_front();
            chk(t, got, e);
        end
    endtask

    task automatic send(scan_pkt_t p, string tag);
        logic [15:0] e0, e1;
        shift_word(p, 1'b0);
        chk("R3 csb idle before apply", {80'h0, m0_csb, m1_csb}, {80'h0, 16'hFFFF, 16'hFFFF});
        apply_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        e0 = p.p0.csb ? 16'hFFFF : ~(16'h1 << p.sel);
        e1 = p.p1.csb ? 16'hFFFF : ~(16'h1 << p.sel);
        chk("R4 slot chip selects", {80'h0, m0_csb, m1_csb}, {80'h0, e0, e1});
        chk("R5 port buses", {30'h0, m0_addr, m0_web, m0_wmask, m1_addr, m1_web, m1_wmask},
            {30'h0, p.p0.addr, p.p0.web, p.p0.mask, p.p1.addr, p.p1.web, p.p1.mask});
        if (!p.p0.csb && !p.p0.web) chk("R5 port0 write word", {80'h0, m0_wdata}, {80'h0, p.p0.data});
        if (!p.p1.csb && !p.p1.web) chk("R5 port1 write word", {80'h0, m1_wdata}, {80'h0, p.p1.data});
        @(posedge clk);
        @(negedge clk);
        apply_en = 1'b0;
        exp_q.push_back(predict(p));
        tag_q.push_back(tag);
    endtask

    function automatic scan_pkt_t mk(logic [3:0] sel,
        logic [15:0] a0, logic [31:0] d0, logic c0, logic w0, logic [3:0] m0,
        logic [15:0] a1, logic [31:0] d1, logic c1, logic w1, logic [3:0] m1);
        scan_pkt_t p;
        p.sel = sel;
        p.p0.addr = a0; p.p0.data = d0; p.p0.csb = c0; p.p0.web = w0; p.p0.mask = m0;
        p.p1.addr = a1; p.p1.data = d1; p.p1.csb = c1; p.p1.web = w1; p.p1.mask = m1;
        return p;
    endfunction

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int s = 0; s < 16; s++) begin
            dout0[s] = 32'h0;
            dout1[s] = 32'h0;
            for (int a = 0; a < 64; a++) begin
                mem[s][a] = 32'h0;
                shadow[s][a] = 32'h0;
            end
        end
        rst = 1'b1; scan_en = 1'b0; scan_in = 1'b0; apply_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 csb after reset", {80'h0, m0_csb, m1_csb}, {80'h0, 16'hFFFF, 16'hFFFF});
        exp_q.push_back(mk(4'd0, 16'h0, 32'h0, 1'b1, 1'b0, 4'h0, 16'h0, 32'h0, 1'b1, 1'b0, 4'h0));
        tag_q.push_back("R1 reset word");

        // R2/R7: idle word on unused slot comes back unchanged
        send(mk(4'd5, 16'hA5C3, 32'h0BADBEEF, 1'b1, 1'b1, 4'h9,
                16'h3C5A, 32'hFEEDF00D, 1'b1, 1'b0, 4'h6), "R2 loopback");
        // R7: write on port 0, idle port 1 keeps its data
        send(mk(4'd0, 16'd1, 32'h00000001, 1'b0, 1'b0, 4'hF,
                16'd9, 32'h12345678, 1'b1, 1'b1, 4'h0), "R7 write echo slot0");
        send(mk(4'd0, 16'd0, 32'h0, 1'b1, 1'b0, 4'h0,
                16'd2, 32'h00000002, 1'b0, 1'b0, 4'hF), "R7 port1 write echo");
        // R6: both ports read
        send(mk(4'd0, 16'd1, 32'h0, 1'b0, 1'b1, 4'h0,
                16'd2, 32'h0, 1'b0, 1'b1, 4'h0), "R6 dual read slot0");
        // R5: byte mask
        send(mk(4'd3, 16'd7, 32'hAABBCCDD, 1'b0, 1'b0, 4'hF,
                16'd0, 32'h0, 1'b1, 1'b0, 4'h0), "R7 write slot3");
        send(mk(4'd3, 16'd7, 32'h11223344, 1'b0, 1'b0, 4'h5,
                16'd0, 32'h0, 1'b1, 1'b0, 4'h0), "R5 masked write slot3");
        send(mk(4'd3, 16'd0, 32'h0, 1'b1, 1'b0, 4'h0,
                16'd7, 32'hFFFFFFFF, 1'b0, 1'b1, 4'h0), "R6 read masked word slot3");
        // R9: single-port slot, port 1 lane is zero
        send(mk(4'd9, 16'd3, 32'hCAFEF00D, 1'b0, 1'b0, 4'hF,
                16'd0, 32'h0, 1'b1, 1'b0, 4'h0), "R7 write slot9");
        send(mk(4'd9, 16'd3, 32'h0, 1'b0, 1'b1, 4'h0,
                16'd3, 32'h0000DEAD, 1'b0, 1'b1, 4'h0), "R9 single port read slot9");
        send(mk(4'd4, 16'd63, 32'h55555555, 1'b0, 1'b1, 4'h0,
                16'd1, 32'h0, 1'b1, 1'b1, 4'h0), "R6 read unwritten slot4");
        // R8: final drain with apply held high during the shift
        shift_word(mk(4'd0, 16'h0, 32'h0, 1'b1, 1'b0, 4'h0, 16'h0, 32'h0, 1'b1, 1'b0, 4'h0), 1'b1);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule